// File: doc/BRIEF.md
# Software-Accessible Register Field with Access Side-Effects

This block is a single storage field inside a memory-mapped register. It keeps a value of parameterised width. Each cycle it can take a new value from two groups of update sources. The software group is a decoded read or write that selects this register. The hardware group is a load of a hardware-supplied value, a set pulse and a clear pulse.

Parameters fix several things at elaboration time: how a software write modifies the stored bits, whether a read has a side-effect, the reset value, the reset style, and which group wins when both act in the same cycle. The address decoder and the bus interface sit outside this block. They present a request qualifier, a read/write flag, a select strobe and the write data. The stored value goes to the readback path and, when enabled, to hardware.

Top module: `rf_cell`

## Requirements
- R1: The bitwise write modes act on a selected write (`req`=1, `req_wr`=1, `sel`=1) and compute next from old value and `wdata` as follows. WR_MODE=1 gives old|wdata. WR_MODE=2 gives old&~wdata. WR_MODE=3 gives old^wdata. WR_MODE=4 gives old|~wdata. WR_MODE=5 gives old&wdata. WR_MODE=6 gives old^~wdata.
- R2: The whole-word write modes act on a selected write and give: WR_MODE=0, next = `wdata`; WR_MODE=7, next = all zeros; WR_MODE=8, next = all ones.
- R3: A selected read (`req`=1, `req_wr`=0, `sel`=1) sets the field to all zeros when RD_MODE=1 and to all ones when RD_MODE=2. With RD_MODE=0 a read changes nothing.
- R4: Within the hardware group, `hw_ld` (next = `hw_d`) beats `hw_set` (all ones), which beats `hw_clr` (all zeros).
- R5: When a software event and a hardware event occur in the same cycle, the software result is stored if SW_FIRST=1 and the hardware result is stored if SW_FIRST=0. A read and a write cannot both occur in one request.
- R6: With no software hit and no hardware event, the field holds its value. A request with `sel`=0, or `sel` with `req`=0, has no effect.
- R7: Reset loads RST_VAL. RST_STYLE=0 is synchronous and active-high. RST_STYLE=1 is asynchronous and active-high. RST_STYLE=2 is asynchronous and active-low. The asynchronous styles take effect before the next clock edge.
- R8: `rd_q` always shows the stored value. `hw_q` shows the stored value when HW_RD=1 and zero when HW_RD=0. An update becomes visible after the clock edge on which its inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Reset; its active level and timing are set by RST_STYLE |
| req | input | 1 | Valid access request from the decoder |
| req_wr | input | 1 | 1 = write, 0 = read |
| sel | input | 1 | Register select strobe |
| wdata | input | W | Write data |
| hw_ld | input | 1 | Hardware load enable |
| hw_d | input | W | Hardware load value |
| hw_set | input | 1 | Hardware set-all pulse |
| hw_clr | input | 1 | Hardware clear-all pulse |
| hw_q | output | W | Stored value to hardware (zero when HW_RD=0) |
| rd_q | output | W | Stored value to readback |

## Verification
Every update source has a one-edge latency. The bench applies inputs at a falling edge and compares `rd_q` and `hw_q` at the following falling edge, against a model advanced by exactly one step.

The one exception is asynchronous reset. For those styles the reset value is checked one nanosecond after `rst` is asserted, with no clock edge in between. In the same moment the synchronous-style instances are checked to confirm they still hold their previous value.

Eighteen instances run side by side and cover every write mode, each read option, each reset style and both precedence orders.

// File: rtl/rf_cell.sv
module rf_cell #(
  parameter int             W         = 8,
  parameter int             WR_MODE   = 0,
  parameter int             RD_MODE   = 0,
  parameter logic [W-1:0]   RST_VAL   = '0,
  parameter int             RST_STYLE = 0,
  parameter bit             SW_FIRST  = 1'b1,
  parameter bit             HW_RD     = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req,
  input  logic         req_wr,
  input  logic         sel,
  input  logic [W-1:0] wdata,
  input  logic         hw_ld,
  input  logic [W-1:0] hw_d,
  input  logic         hw_set,
  input  logic         hw_clr,
  output logic [W-1:0] hw_q,
  output logic [W-1:0] rd_q
);
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic [W-1:0] q, wr_val, sw_val, hw_val, nxt;
  logic         rd_hit, wr_hit, sw_hit, hw_hit, load;

  always_comb begin
    case (WR_MODE)
      1:       wr_val = q | wdata;
      2:       wr_val = q & ~wdata;
      3:       wr_val = q ^ wdata;
      4:       wr_val = q | ~wdata;
      5:       wr_val = q & wdata;
      6:       wr_val = q ^ ~wdata;
      7:       wr_val = '0;
      8:       wr_val = ONES;
      default: wr_val = wdata;
    endcase
  end

  assign rd_hit = req & ~req_wr & sel & (RD_MODE != 0);
  assign wr_hit = req & req_wr & sel;
  assign sw_hit = rd_hit | wr_hit;
  assign sw_val = rd_hit ? ((RD_MODE == 2) ? ONES : '0) : wr_val;

  assign hw_hit = hw_ld | hw_set | hw_clr;
  assign hw_val = hw_ld ? hw_d : (hw_set ? ONES : '0);

  assign load = sw_hit | hw_hit;
  assign nxt  = SW_FIRST ? (sw_hit ? sw_val : hw_val)
                         : (hw_hit ? hw_val : sw_val);

  generate
    if (RST_STYLE == 1) begin : g_async_hi
      always_ff @(posedge clk or posedge rst)
        if (rst)       q <= RST_VAL;
        else if (load) q <= nxt;
    end else if (RST_STYLE == 2) begin : g_async_lo
      always_ff @(posedge clk or negedge rst)
        if (!rst)      q <= RST_VAL;
        else if (load) q <= nxt;
    end else begin : g_sync
      always_ff @(posedge clk)
        if (rst)       q <= RST_VAL;
        else if (load) q <= nxt;
    end
  endgenerate

  assign rd_q = q;
  assign hw_q = HW_RD ? q : '0;
endmodule

// File: rtl/rf_cell_chk.sv
module rf_cell_chk #(
  parameter int           W         = 8,
  parameter int           WR_MODE   = 0,
  parameter int           RD_MODE   = 0,
  parameter logic [W-1:0] RST_VAL   = '0,
  parameter int           RST_STYLE = 0,
  parameter bit           SW_FIRST  = 1'b1,
  parameter bit           HW_RD     = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic         req,
  input logic         req_wr,
  input logic         sel,
  input logic [W-1:0] wdata,
  input logic         hw_ld,
  input logic [W-1:0] hw_d,
  input logic         hw_set,
  input logic         hw_clr,
  input logic [W-1:0] hw_q,
  input logic [W-1:0] rd_q
);
  logic rst_act, sw_act, hw_any;
  assign rst_act = (RST_STYLE == 2) ? ~rst : rst;
  assign sw_act  = req & sel & (req_wr | (RD_MODE != 0));
  assign hw_any  = hw_ld | hw_set | hw_clr;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst_act)
    (!(req && sel) && !hw_any) |=> $stable(rd_q)); // R6

  AST_HW_LOAD: assert property (@(posedge clk) disable iff (rst_act)
    ((!SW_FIRST || !sw_act) && hw_ld) |=> (rd_q == $past(hw_d))); // R4

  AST_HW_SET: assert property (@(posedge clk) disable iff (rst_act)
    ((!SW_FIRST || !sw_act) && hw_set && !hw_ld) |=> (rd_q == {W{1'b1}})); // R4

  AST_HW_CLR: assert property (@(posedge clk) disable iff (rst_act)
    ((!SW_FIRST || !sw_act) && hw_clr && !hw_set && !hw_ld) |=> (rd_q == '0)); // R4

  AST_RD_SIDE: assert property (@(posedge clk) disable iff (rst_act)
    ((RD_MODE != 0) && req && !req_wr && sel && (SW_FIRST || !hw_any))
      |=> (rd_q == ((RD_MODE == 2) ? {W{1'b1}} : '0))); // R3

  AST_HW_VIEW: assert property (@(posedge clk) disable iff (rst_act)
    hw_q == (HW_RD ? rd_q : '0)); // R8
endmodule

bind rf_cell rf_cell_chk #(
  .W(W), .WR_MODE(WR_MODE), .RD_MODE(RD_MODE), .RST_VAL(RST_VAL),
  .RST_STYLE(RST_STYLE), .SW_FIRST(SW_FIRST), .HW_RD(HW_RD)
) u_chk (.*);

// File: tb/rf_cell_bench.sv
`timescale 1ns/1ps
module rf_cell_bench;
  localparam int N = 18;

  logic clk = 1'b0;
  logic rst_hi = 1'b1;
  logic req = 0, req_wr = 0, sel = 0, hw_ld = 0, hw_set = 0, hw_clr = 0;
  logic [7:0] wdata = '0, hw_d = '0;
  logic [7:0] rdq [N];
  logic [7:0] hwq [N];
  logic [7:0] mdl [N];
  logic [7:0] exq [N];
  string      tg  [N];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  for (genvar k = 0; k < N; k++) begin : g_inst
    localparam int RS = (k / 3) % 3;
    logic rk;
    assign rk = (RS == 2) ? ~rst_hi : rst_hi;
    rf_cell #(
      .W(8), .WR_MODE(k % 9), .RD_MODE(k % 3), .RST_VAL(8'hA5 ^ 8'(k)),
      .RST_STYLE(RS), .SW_FIRST(k >= 9), .HW_RD(k != 17)
    ) u_rf_cell (
      .clk(clk), .rst(rk), .req(req), .req_wr(req_wr), .sel(sel),
      .wdata(wdata), .hw_ld(hw_ld), .hw_d(hw_d), .hw_set(hw_set),
      .hw_clr(hw_clr), .hw_q(hwq[k]), .rd_q(rdq[k])
    );
  end

  function automatic logic [7:0] rv(int k);
    return 8'hA5 ^ 8'(k);
  endfunction

  task automatic predict(int k, logic [7:0] o, output logic [7:0] nv, output string t);
    int wm = k % 9;
    int rm = k % 3;
    bit swf = (k >= 9);
    bit rh = req && !req_wr && sel && (rm != 0);
    bit wh = req && req_wr && sel;
    bit hh = hw_ld || hw_set || hw_clr;
    logic [7:0] sv, hv;
    case (wm)
      1: sv = o | wdata;   2: sv = o & ~wdata;  3: sv = o ^ wdata;
      4: sv = o | ~wdata;  5: sv = o & wdata;   6: sv = o ^ ~wdata;
      7: sv = 8'h00;       8: sv = 8'hFF;       default: sv = wdata;
    endcase
    if (rh) sv = (rm == 2) ? 8'hFF : 8'h00;
    hv = hw_ld ? hw_d : (hw_set ? 8'hFF : 8'h00);
    if ((rh || wh) && hh) begin nv = swf ? sv : hv; t = "R5"; end
    else if (rh) begin nv = sv; t = "R3"; end
    else if (wh) begin nv = sv; t = (wm >= 1 && wm <= 6) ? "R1" : "R2"; end
    else if (hh) begin nv = hv; t = "R4"; end
    else begin nv = o; t = "R6"; end
  endtask

  task automatic chk(int k, logic [7:0] exp, string t);
    logic [7:0] eh = (k != 17) ? exp : 8'h00;
    n_chk++;
    if (rdq[k] !== exp) begin
      n_bad++;
      $display("FAIL %s inst %0d rd_q actual %h expected %h", t, k, rdq[k], exp);
    end
    n_chk++;
    if (hwq[k] !== eh) begin
      n_bad++;
      $display("FAIL R8 inst %0d hw_q actual %h expected %h", k, hwq[k], eh);
    end
  endtask

  task automatic idle();
    req = 0; req_wr = 0; sel = 0; hw_ld = 0; hw_set = 0; hw_clr = 0;
  endtask

  task automatic step();
    for (int k = 0; k < N; k++) predict(k, mdl[k], exq[k], tg[k]);
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < N; k++) begin
      chk(k, exq[k], tg[k]);
      mdl[k] = exq[k];
    end
  endtask

  task automatic drive(bit r, bit w, bit s, logic [7:0] d, bit l, logic [7:0] hd, bit st, bit cl);
    req = r; req_wr = w; sel = s; wdata = d; hw_ld = l; hw_d = hd; hw_set = st; hw_clr = cl;
    step();
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    idle();
    rst_hi = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < N; k++) begin mdl[k] = rv(k); chk(k, rv(k), "R7"); end
    rst_hi = 1'b0;

    drive(1, 1, 1, 8'h3C, 0, 8'h00, 0, 0);
    drive(1, 1, 1, 8'hF0, 0, 8'h00, 0, 0);
    drive(1, 1, 0, 8'h0F, 0, 8'h00, 0, 0);
    drive(0, 1, 1, 8'h55, 0, 8'h00, 0, 0);
    drive(1, 0, 1, 8'h00, 0, 8'h00, 0, 0);
    drive(0, 0, 0, 8'h00, 1, 8'h5A, 0, 0);
    drive(0, 0, 0, 8'h00, 1, 8'hC3, 1, 1);
    drive(0, 0, 0, 8'h00, 0, 8'h00, 1, 1);
    drive(0, 0, 0, 8'h00, 0, 8'h00, 0, 1);
    drive(1, 1, 1, 8'h96, 0, 8'h00, 1, 0);
    drive(1, 0, 1, 8'h00, 1, 8'h77, 0, 0);
    drive(1, 1, 1, 8'h00, 0, 8'h00, 0, 1);
    drive(0, 0, 0, 8'h00, 0, 8'h00, 0, 0);

    for (int v = 0; v < 3000; v++) begin
      req    = ($urandom % 4) != 0;
      req_wr = $urandom % 2;
      sel    = ($urandom % 3) != 0;
      wdata  = 8'($urandom);
      hw_ld  = ($urandom % 5) == 0;
      hw_d   = 8'($urandom);
      hw_set = ($urandom % 5) == 0;
      hw_clr = ($urandom % 5) == 0;
      step();
    end

    idle();
    drive(0, 0, 0, 8'h00, 1, 8'h00, 0, 0);
    idle();
    rst_hi = 1'b1;
    #1;
    for (int k = 0; k < N; k++)
      chk(k, (((k / 3) % 3) != 0) ? rv(k) : mdl[k], "R7");
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < N; k++) begin mdl[k] = rv(k); chk(k, rv(k), "R7"); end
    rst_hi = 1'b0;
    drive(0, 0, 0, 8'h00, 0, 8'h00, 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500us;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule